// File: doc/BRIEF.md
# Transmit Trail Trace Inserter

This block feeds the trace overhead byte of an outgoing E3 frame stream. A host writes a 16-byte trail access point identifier and a small control word into staging registers. On each frame strobe from the transmit formatter, the block presents one processed identifier byte on its output. It steps through the sixteen positions in a repeating cycle.

Three optional transforms are applied to each byte in a fixed order:
- multiframe alignment marking on the top bit;
- bit reversal for least-significant-bit-first transmission;
- a final inversion.

Staged host data is copied into the working copy only when the sequence returns to position 0. The transmitted 16-byte cycle is therefore never a mix of old and new identifiers or settings.

Top module: `trace_inserter`

## Requirements
- R1: After reset `traceByte` is 0x00, the position counter is 0, and all staged and working bytes and control bits are 0.
- R2: A `frameStrobe` sampled high at a rising edge makes `traceByte`, from that edge on, carry the processed byte at the current position. The position then advances by one and wraps from 15 to 0.
- R3: A host write to address 0..15 stages identifier byte N = address. A write to address 16 stages the control word: bit 0 enables alignment, bit 1 selects LSB-first order, bit 2 inverts the output. Staged values are copied to the working set only by a strobe at position 0, and that strobe already uses the new values. Strobes at positions 1..15 use the previously copied set.
- R4: With alignment enabled, bit 7 of the byte is forced to 1 at position 0 and to 0 at positions 1..15, before any reordering.
- R5: With LSB-first selected, the byte is bit-reversed (bit i goes to bit 7-i) after alignment marking.
- R6: With inversion selected, every bit of the byte is complemented as the last step.
- R7: Host writes to addresses 17..31 change neither the staged identifier nor the control word.
- R8: Without a strobe, `traceByte` and the position counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 5 | Host write address (0..15 bytes, 16 control) |
| hostWrData | input | 8 | Host write data |
| frameStrobe | input | 1 | Request for the next trace byte |
| traceByte | output | 8 | Processed identifier byte for the overhead slot |

## Verification
Every result of this block appears exactly one clock after the strobe edge that requests it. A host write becomes visible only on the next position-0 strobe after it, so its effect lags by one to sixteen frames depending on where the write lands. The driver changes inputs on falling edges and pushes the predicted byte when it raises the strobe. The monitor waits for a rising edge with the strobe high and compares on the following falling edge. Idle stretches are checked against the last byte to show that the output holds.

// File: rtl/trace_ins_pkg.sv
package trace_ins_pkg;
  localparam int TRACE_LEN = 16;
  localparam int BYTE_W    = 8;
  localparam int POS_W     = $clog2(TRACE_LEN);
  localparam int ADDR_W    = POS_W + 1;
  localparam int CTRL_ADDR = TRACE_LEN;

  // working or staged control settings
  typedef struct packed {
    logic invertOut;
    logic lsbFirst;
    logic alignEn;
  } traceCtl_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic             advance;
    logic             commit;
    logic [POS_W-1:0] pos;
  } seqCmd_t;
endpackage

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
  import trace_ins_pkg::*;
#(
  parameter int LEN = TRACE_LEN
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStrobe,
  output seqCmd_t cmd
);
  localparam int PW = $clog2(LEN);
  localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);

  logic [PW-1:0] posQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ <= '0;
    end else if (frameStrobe) begin
      posQ <= (posQ == LAST_POS) ? '0 : posQ + 1'b1;
    end
  end

  always_comb begin
    cmd.advance = frameStrobe;
    cmd.commit  = frameStrobe && (posQ == '0);
    cmd.pos     = posQ;
  end
endmodule

// File: rtl/trace_byte_fmt.sv
module trace_byte_fmt
  import trace_ins_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] rawByte,
  input  traceCtl_t    ctl,
  input  logic         isFirst,
  output logic [W-1:0] outByte
);
  logic [W-1:0] marked;
  logic [W-1:0] reversed;
  logic [W-1:0] ordered;

  always_comb begin
    marked = rawByte;
    if (ctl.alignEn) marked[W-1] = isFirst;
  end

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : gRev
      assign reversed[gi] = marked[W-1-gi];
    end
  endgenerate

  assign ordered = ctl.lsbFirst ? reversed : marked;
  assign outByte = ctl.invertOut ? ~ordered : ordered;
endmodule

// File: rtl/trace_byte_path.sv
module trace_byte_path
  import trace_ins_pkg::*;
#(
  parameter int LEN = TRACE_LEN,
  parameter int W   = BYTE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic [$clog2(LEN):0]       hostAddr,
  input  logic [W-1:0]               hostWrData,
  input  seqCmd_t                    cmd,
  output logic [W-1:0]               traceByte
);
  localparam int PW = $clog2(LEN);
  localparam int AW = PW + 1;

  logic [W-1:0] shadowMem [LEN];
  logic [W-1:0] activeMem [LEN];
  traceCtl_t    shadowCtl, activeCtl;

  logic         ctlSel;
  logic [W-1:0] srcByte;
  traceCtl_t    srcCtl;
  logic [W-1:0] fmtByte;

  assign ctlSel = hostWrEn && (hostAddr == AW'(LEN));

  genvar gi;
  generate
    for (gi = 0; gi < LEN; gi++) begin : gSlot
      logic slotSel;
      assign slotSel = hostWrEn && (hostAddr == AW'(gi));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowMem[gi] <= '0;
          activeMem[gi] <= '0;
        end else begin
          if (slotSel)    shadowMem[gi] <= hostWrData;
          if (cmd.commit) activeMem[gi] <= shadowMem[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCtl <= '0;
      activeCtl <= '0;
    end else begin
      if (ctlSel)     shadowCtl <= traceCtl_t'(hostWrData[2:0]);
      if (cmd.commit) activeCtl <= shadowCtl;
    end
  end

  // the committing strobe already uses the freshly staged set
  always_comb begin
    srcByte = cmd.commit ? shadowMem[cmd.pos] : activeMem[cmd.pos];
    srcCtl  = cmd.commit ? shadowCtl : activeCtl;
  end

  trace_byte_fmt #(.W(W)) u_fmt (
    .rawByte (srcByte),
    .ctl     (srcCtl),
    .isFirst (cmd.pos == '0),
    .outByte (fmtByte)
  );

  always_ff @(posedge clk) begin
    if (!rstN)            traceByte <= '0;
    else if (cmd.advance) traceByte <= fmtByte;
  end
endmodule

// File: rtl/trace_inserter.sv
module trace_inserter
  import trace_ins_pkg::*;
#(
  parameter int LEN = TRACE_LEN,
  parameter int W   = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [$clog2(LEN):0] hostAddr,
  input  logic [W-1:0]         hostWrData,
  input  logic                 frameStrobe,
  output logic [W-1:0]         traceByte
);
  seqCmd_t seqCmd;

  trace_seq_ctrl #(.LEN(LEN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameStrobe (frameStrobe),
    .cmd         (seqCmd)
  );

  trace_byte_path #(.LEN(LEN), .W(W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .cmd        (seqCmd),
    .traceByte  (traceByte)
  );
endmodule

// File: rtl/trace_ins_chk.sv
module trace_ins_chk
  import trace_ins_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameStrobe,
  input logic [BYTE_W-1:0] traceByte,
  input logic [POS_W-1:0] curPos,
  input logic             commit
);
  localparam logic [POS_W-1:0] LAST = POS_W'(TRACE_LEN - 1);

  assert_pos_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && curPos == LAST) |=> (curPos == '0));

  assert_pos_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && curPos != LAST) |=> (curPos == $past(curPos) + 1'b1));

  assert_pos_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(curPos));

  assert_byte_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(traceByte));

  assert_commit_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (frameStrobe && curPos == '0));
endmodule

bind trace_inserter trace_ins_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameStrobe (frameStrobe),
  .traceByte   (traceByte),
  .curPos      (seqCmd.pos),
  .commit      (seqCmd.commit)
);

// File: tb/trace_inserter_tb_top.sv
module trace_inserter_tb_top;
  localparam time HALF = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       frameStrobe = 1'b0;
  logic [7:0] traceByte;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  logic [7:0] lastExp = 8'h00;

  // bench model
  logic [7:0] mShadow [16];
  logic [7:0] mActive [16];
  logic [2:0] mShCtl = '0, mActCtl = '0;
  int         mPos = 0;

  always #HALF clk = ~clk;

  trace_inserter dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .frameStrobe(frameStrobe), .traceByte(traceByte)
  );

  function automatic logic [7:0] predict();
    logic [7:0] b, r;
    if (mPos == 0) begin
      for (int i = 0; i < 16; i++) mActive[i] = mShadow[i];
      mActCtl = mShCtl;
    end
    b = mActive[mPos];
    if (mActCtl[0]) b[7] = (mPos == 0);
    if (mActCtl[1]) begin
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      b = r;
    end
    if (mActCtl[2]) b = ~b;
    mPos = (mPos + 1) % 16;
    return b;
  endfunction

  task automatic hostWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 5'(addr); hostWrData = data;
    if (addr < 16) mShadow[addr] = data;
    else if (addr == 16) mShCtl = data[2:0];
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frameStrobe = 1'b1;
      expQ.push_back(predict());
      @(negedge clk);
      frameStrobe = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: traceByte=%02h expected=%02h", req, act, exp);
    end
  endtask

  // R8: output holds over idle cycles
  task automatic idleHold(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    check("R8", traceByte, lastExp);
  endtask

  // monitor: result due one edge after the strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (rstN && frameStrobe) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          check("R2", traceByte, 8'hxx);
        end else begin
          lastExp = expQ.pop_front();
          check("R2-R6", traceByte, lastExp);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mShadow[i] = '0; mActive[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", traceByte, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", traceByte, 8'h00);

    // R1: first frames after reset send zeros
    frames(2);
    frames(14);

    // R2/R3: load identifier, cycle twice through it, plain mode
    for (int i = 0; i < 16; i++) hostWrite(i, 8'(i * 8'h11 + 8'h03));
    frames(32);
    idleHold(5);

    // R3: mid-cycle writes wait for the next position 0
    frames(5);
    hostWrite(9, 8'hA5);
    hostWrite(16, 8'h01);
    frames(11);
    frames(16);

    // R4: alignment marking on bytes with a mix of top bits
    for (int i = 0; i < 16; i++) hostWrite(i, (i % 2) ? 8'h8C : 8'h31);
    frames(16);

    // R5: LSB-first with alignment
    hostWrite(16, 8'h03);
    frames(16);

    // R6: inversion only, then all three
    hostWrite(16, 8'h04);
    frames(16);
    hostWrite(16, 8'h07);
    frames(16);
    idleHold(3);

    // R7: out-of-range addresses leave staged data untouched
    hostWrite(17, 8'hFF);
    hostWrite(31, 8'hFF);
    hostWrite(24, 8'h5A);
    frames(32);

    // R5 alone
    hostWrite(16, 8'h02);
    for (int i = 0; i < 16; i++) hostWrite(i, 8'(8'h01 << (i % 8)));
    frames(32);
    idleHold(4);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: %0d results missing, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule